// File: doc/BRIEF.md
# USB Start-of-Frame Capture Unit

This block sits after a USB receiver's packet decoder and watches every token that the decoder reports. When the token's PID byte identifies a start-of-frame packet, the unit stores the 11-bit frame number carried in the token, splitting it across a low byte register and a high byte register. It also checks the 5-bit CRC that protects the frame number and reports the result as a pair of flags, one for a good CRC and one for a bad one.

Each start-of-frame also sets a sticky event flag that firmware clears with a one-cycle strobe. A small two-state machine holds this flag. In state ST_WAIT the flag is clear. Transition T_DETECT takes the machine to ST_FLAGGED when a start-of-frame token arrives. Transition T_CLEAR takes it back to ST_WAIT when firmware clears the flag and no start-of-frame arrives in the same cycle. In every other case the machine keeps its state. The interrupt output is the flag gated by an enable input. Bit-level reception, NRZI decoding and token framing are done upstream and are not part of this block.

Top module: `usb_sof_capture`

## Requirements
- R1: While rst_n is low and in the first cycle after its release, frame_lo, frame_hi, crc_good, crc_err, sof_flag and sof_irq are all 0.
- R2: A start-of-frame hit is a cycle with pid_valid high and pid_byte equal to 8'hA5, where bits 3:0 hold the PID 4'b0101 and bits 7:4 hold its bitwise complement. No other cycle changes frame_lo, frame_hi, crc_good or crc_err. This covers other PIDs, a PID whose upper nibble is not the complement, and any pid_byte while pid_valid is low.
- R3: One clock after a hit, frame_lo equals token_data[7:0], where token_data[10:0] carries the frame number.
- R4: One clock after a hit, frame_hi[2:0] equals token_data[10:8] and frame_hi[7:3] is 0.
- R5: One clock after every hit, exactly one of crc_good and crc_err is 1. crc_good is 1 when the CRC field is correct. The field is correct when token_data[11+k] equals the inverse of bit 4-k of the residue, for k = 0..4. The residue is formed by shifting the frame bits in from bit 0 to bit 10 through a 5-bit register that starts at 5'b11111 and uses the generator x^5+x^2+1.
- R6: One clock after a hit, sof_flag is 1. It stays 1 until firmware clears it.
- R7: A clr_sof pulse in a cycle with no hit makes sof_flag 0 one clock later. When clr_sof and a hit fall in the same cycle, the flag stays 1.
- R8: A hit while sof_flag is already 1 still rewrites frame_lo, frame_hi, crc_good and crc_err, and sof_flag stays 1.
- R9: sof_irq is 1 exactly when sof_flag is 1 and sof_irq_en is 1. It follows sof_irq_en in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pid_valid | input | 1 | Strobe: pid_byte and token_data are valid this cycle |
| pid_byte | input | 8 | Received PID byte, with the PID in bits 3:0 and its complement in bits 7:4 |
| token_data | input | 16 | Token payload, with the frame number in bits 10:0 and the CRC field in bits 15:11 |
| clr_sof | input | 1 | Firmware strobe that clears the start-of-frame flag |
| sof_irq_en | input | 1 | Interrupt enable |
| frame_lo | output | 8 | Frame number bits 7:0 |
| frame_hi | output | 8 | Frame number bits 10:8 in bits 2:0; upper bits are 0 |
| crc_good | output | 1 | The last start-of-frame had a correct CRC |
| crc_err | output | 1 | The last start-of-frame had a corrupted CRC |
| sof_flag | output | 1 | Sticky start-of-frame event flag |
| sof_irq | output | 1 | Interrupt request |

## Verification
The frame numbers sent are all zeros, all ones, and the alternating patterns 0x555 and 0x2AA. Between them they show a byte split that is off by one or a lost high bit. Each frame is sent once with a correct CRC field and once with a single bit flipped, so a wrong CRC generator, a wrong bit order or a missing final inversion shows up as a good/error pair that disagrees with the model. Tokens with a different PID, a PID with a corrupted complement nibble, and a start-of-frame byte with pid_valid low show whether the captured state is ever disturbed. Clear strobes are placed alone, in the same cycle as a hit, and while the flag is already set, so that the T_DETECT and T_CLEAR transitions and the priority between them are each seen, with the interrupt enable toggled throughout.

// File: rtl/usb_sof_pkg.sv
package usb_sof_pkg;

    typedef enum logic {
        ST_WAIT    = 1'b0,
        ST_FLAGGED = 1'b1
    } sof_state_e;

    localparam int unsigned PID_W   = 4;
    localparam logic [3:0]  PID_SOF = 4'b0101;

endpackage

// File: rtl/sof_pid_match.sv
module sof_pid_match
    import usb_sof_pkg::*;
#(
    parameter int unsigned NIB_W = PID_W
) (
    input  logic               pid_valid,
    input  logic [2*NIB_W-1:0] pid_byte,
    input  logic [NIB_W-1:0]   pid_code,
    output logic               hit
);
    logic [NIB_W-1:0] lo_nib;
    logic [NIB_W-1:0] hi_nib;

    always_comb begin
        lo_nib = pid_byte[NIB_W-1:0];
        hi_nib = pid_byte[2*NIB_W-1:NIB_W];
        hit    = pid_valid && (lo_nib == pid_code) && (hi_nib == ~lo_nib);
    end
endmodule

// File: rtl/sof_crc5_check.sv
module sof_crc5_check #(
    parameter int unsigned      DATA_W = 11,
    parameter int unsigned      CRC_W  = 5,
    parameter logic [CRC_W-1:0] POLY   = 5'b00101
) (
    input  logic [DATA_W-1:0] data,
    input  logic [CRC_W-1:0]  crc_field,
    output logic              crc_ok
);
    logic [CRC_W-1:0] residue;
    logic [CRC_W-1:0] expect_field;
    logic             fb;

    always_comb begin
        residue = '1;
        for (int i = 0; i < DATA_W; i++) begin
            fb      = data[i] ^ residue[CRC_W-1];
            residue = {residue[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
        end
        for (int k = 0; k < CRC_W; k++) begin
            expect_field[k] = ~residue[CRC_W-1-k];
        end
        crc_ok = (crc_field == expect_field);
    end
endmodule

// File: rtl/usb_sof_capture.sv
module usb_sof_capture
    import usb_sof_pkg::*;
#(
    parameter int unsigned FRAME_W = 11,
    parameter int unsigned CRC_W   = 5,
    parameter int unsigned BYTE_W  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      pid_valid,
    input  logic [2*PID_W-1:0]        pid_byte,
    input  logic [FRAME_W+CRC_W-1:0]  token_data,
    input  logic                      clr_sof,
    input  logic                      sof_irq_en,
    output logic [BYTE_W-1:0]         frame_lo,
    output logic [BYTE_W-1:0]         frame_hi,
    output logic                      crc_good,
    output logic                      crc_err,
    output logic                      sof_flag,
    output logic                      sof_irq
);
    localparam int unsigned HI_W  = FRAME_W - BYTE_W;
    localparam int unsigned PAD_W = BYTE_W - HI_W;

    sof_state_e state_q, state_d;
    logic       hit;
    logic       crc_ok;
    logic [FRAME_W-1:0] frame_in;
    logic [CRC_W-1:0]   crc_in;

    assign frame_in = token_data[FRAME_W-1:0];
    assign crc_in   = token_data[FRAME_W+CRC_W-1:FRAME_W];

    sof_pid_match #(.NIB_W(PID_W)) u_pid (
        .pid_valid (pid_valid),
        .pid_byte  (pid_byte),
        .pid_code  (PID_SOF),
        .hit       (hit)
    );

    sof_crc5_check #(.DATA_W(FRAME_W), .CRC_W(CRC_W)) u_crc (
        .data      (frame_in),
        .crc_field (crc_in),
        .crc_ok    (crc_ok)
    );

    // Next-state logic: T_DETECT wins over T_CLEAR.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT:    if (hit) state_d = ST_FLAGGED;
            ST_FLAGGED: if (clr_sof && !hit) state_d = ST_WAIT;
            default:    state_d = ST_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_WAIT;
        else        state_q <= state_d;
    end

    // Captured frame number and CRC status, rewritten on every hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_lo <= '0;
            frame_hi <= '0;
            crc_good <= 1'b0;
            crc_err  <= 1'b0;
        end else if (hit) begin
            frame_lo <= frame_in[BYTE_W-1:0];
            frame_hi <= {{PAD_W{1'b0}}, frame_in[FRAME_W-1:BYTE_W]};
            crc_good <= crc_ok;
            crc_err  <= !crc_ok;
        end
    end

    always_comb begin
        sof_flag = (state_q == ST_FLAGGED);
        sof_irq  = sof_flag && sof_irq_en;
    end
endmodule

// File: rtl/usb_sof_capture_chk.sv
module usb_sof_capture_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        pid_valid,
    input logic [7:0]  pid_byte,
    input logic [15:0] token_data,
    input logic        clr_sof,
    input logic [7:0]  frame_lo,
    input logic [7:0]  frame_hi,
    input logic        crc_good,
    input logic        crc_err,
    input logic        sof_flag
);
    logic port_hit;
    assign port_hit = pid_valid && (pid_byte == 8'hA5);

    a_r3_frame_lo: assert property (@(posedge clk) disable iff (!rst_n)
        port_hit |=> frame_lo == $past(token_data[7:0]));

    a_r4_frame_hi: assert property (@(posedge clk) disable iff (!rst_n)
        port_hit |=> frame_hi == {5'b0, $past(token_data[10:8])});

    a_r5_one_hot_status: assert property (@(posedge clk) disable iff (!rst_n)
        port_hit |=> $countones({crc_good, crc_err}) == 1);

    a_r2_ignore_other: assert property (@(posedge clk) disable iff (!rst_n)
        !port_hit |=> $stable(frame_lo) && $stable(frame_hi)
                      && $stable(crc_good) && $stable(crc_err));

    a_r6_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        port_hit |=> sof_flag);

    a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        sof_flag && !clr_sof |=> sof_flag);

    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_sof && !port_hit |=> !sof_flag);
endmodule

bind usb_sof_capture usb_sof_capture_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pid_valid  (pid_valid),
    .pid_byte   (pid_byte),
    .token_data (token_data),
    .clr_sof    (clr_sof),
    .frame_lo   (frame_lo),
    .frame_hi   (frame_hi),
    .crc_good   (crc_good),
    .crc_err    (crc_err),
    .sof_flag   (sof_flag)
);

// File: tb/usb_sof_capture_tb.sv
module usb_sof_capture_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pid_valid = 1'b0;
    logic [7:0]  pid_byte = 8'h00;
    logic [15:0] token_data = 16'h0000;
    logic        clr_sof = 1'b0;
    logic        sof_irq_en = 1'b0;
    logic [7:0]  frame_lo, frame_hi;
    logic        crc_good, crc_err, sof_flag, sof_irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    int m_lo = 0, m_hi = 0, m_good = 0, m_err = 0, m_flag = 0;

    always #5 clk = ~clk;

    usb_sof_capture u_dut (
        .clk(clk), .rst_n(rst_n), .pid_valid(pid_valid), .pid_byte(pid_byte),
        .token_data(token_data), .clr_sof(clr_sof), .sof_irq_en(sof_irq_en),
        .frame_lo(frame_lo), .frame_hi(frame_hi), .crc_good(crc_good),
        .crc_err(crc_err), .sof_flag(sof_flag), .sof_irq(sof_irq)
    );

    function automatic int crc_field_of(input int frame);
        int r = 31;
        int f = 0;
        for (int i = 0; i < 11; i++) begin
            int b = ((frame >> i) & 1) ^ ((r >> 4) & 1);
            r = (r << 1) & 31;
            if (b != 0) r = r ^ 5;
        end
        for (int k = 0; k < 5; k++)
            if (((r >> (4 - k)) & 1) == 0) f = f | (1 << k);
        return f;
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // one clock: model updates at the edge, outputs compared at the falling edge
    task automatic step();
        @(posedge clk);
        if (!rst_n) begin
            m_lo = 0; m_hi = 0; m_good = 0; m_err = 0; m_flag = 0;
        end else begin
            bit hit = pid_valid && pid_byte == 8'hA5;
            if (hit) begin
                int fr = token_data & 16'h07FF;
                int ok = (((token_data >> 11) & 31) == crc_field_of(fr)) ? 1 : 0;
                m_lo = fr & 255;
                m_hi = fr >> 8;
                m_good = ok;
                m_err = 1 - ok;
                m_flag = 1;
            end else if (clr_sof) begin
                m_flag = 0;
            end
        end
        @(negedge clk);
        check("R3", "frame_lo", frame_lo, m_lo);
        check("R4", "frame_hi", frame_hi, m_hi);
        check("R5", "crc_good", crc_good, m_good);
        check("R5", "crc_err", crc_err, m_err);
        check("R6/R7", "sof_flag", sof_flag, m_flag);
        check("R9", "sof_irq", sof_irq, m_flag & sof_irq_en);
    endtask

    task automatic idle_inputs();
        pid_valid = 0; clr_sof = 0; pid_byte = 8'h00; token_data = 16'h0;
    endtask

    task automatic send(input logic [7:0] pb, input int frame, input bit good, input bit clr);
        int crc = crc_field_of(frame);
        if (!good) crc = crc ^ 4;
        pid_valid = 1; pid_byte = pb; clr_sof = clr;
        token_data = 16'((crc << 11) | (frame & 16'h07FF));
        step();
        idle_inputs();
    endtask

    task automatic clear_flag();
        clr_sof = 1; step(); clr_sof = 0;
    endtask

    initial begin
        int frames[4] = '{0, 16'h07FF, 16'h0555, 16'h02AA};
        // R1 reset state
        repeat (3) step();
        check("R1", "sof_flag at reset", sof_flag, 0);
        rst_n = 1;
        step();
        check("R1", "frame_lo after reset", frame_lo, 0);
        // R3 R4 R5 R6 R9: frame patterns with good and bad CRC
        foreach (frames[i]) begin
            sof_irq_en = i[0];
            send(8'hA5, frames[i], 1, 0);
            check("R5", "good crc seen", crc_good, 1);
            step();
            clear_flag();
            send(8'hA5, frames[i], 0, 0);
            check("R5", "bad crc seen", crc_err, 1);
            clear_flag();
        end
        // R2: other PIDs, corrupted complement, no strobe
        send(8'hA5, 16'h0123, 1, 0);
        clear_flag();
        send(8'h69, 16'h0456, 1, 0);
        check("R2", "IN pid ignored", frame_lo, 8'h23);
        send(8'hB5, 16'h0456, 1, 0);
        check("R2", "bad complement ignored", sof_flag, 0);
        pid_byte = 8'hA5; token_data = 16'h0777; step(); idle_inputs();
        check("R2", "no strobe ignored", frame_hi, 1);
        // R8: hit while flag set rewrites data
        send(8'hA5, 16'h0100, 1, 0);
        send(8'hA5, 16'h06EE, 0, 0);
        check("R8", "second hit captured", frame_lo, 8'hEE);
        check("R8", "flag still set", sof_flag, 1);
        // R7: clear and hit together keep the flag
        send(8'hA5, 16'h0321, 1, 1);
        check("R7", "hit beats clear", sof_flag, 1);
        clear_flag();
        check("R7", "clear alone", sof_flag, 0);
        // R9: enable toggling while flag set
        send(8'hA5, 16'h0042, 1, 0);
        for (int j = 0; j < 4; j++) begin
            sof_irq_en = j[0];
            #1;
            check("R9", "irq follows enable", sof_irq, j[0]);
            step();
        end
        clear_flag();
        repeat (3) step();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule